// File: doc/BRIEF.md
# Dual-Channel Logarithmic Peak Meter

This block watches a stereo stream of signed 24-bit audio samples and keeps, for each channel, the largest magnitude seen since that channel was last read. Samples arrive with a valid strobe. Tracking runs only while an enable input is high. Software reads each channel through a small read port: a 4-bit address and a one-cycle read strobe. The result appears one cycle later as a 10-bit word. Its low six bits give the held level as an attenuation code below full scale, in steps of 1 dB.

A read clears only the channel it addresses, so the meter then measures the next interval. The held value is stored as a linear magnitude. A single shared converter turns the addressed magnitude into a decibel code at read time. The converter takes the position of the leading one, which gives about 6 dB per bit, and refines the result with a 16-entry table indexed by the next four magnitude bits.

Top module: `stereo_peak_meter`

## Requirements
- R1: After reset, `rd_data` is 0 and both held levels are zero, so a first read with tracking enabled returns code 63.
- R2: A read strobe latches the readback into `rd_data` one cycle later. Address 4'b0011 selects the left channel and 4'b0100 selects the right channel. Any other address reads 0. Without a strobe, `rd_data` keeps its last value.
- R3: Bits 9..6 of `rd_data` are always 0, and bits 5..0 hold the code.
- R4: Code c means c dB below full scale, where full scale is 2^23. For a held magnitude m, let the ideal value be floor(20·log10(2^23/m)). The code equals that ideal value or the ideal value plus 1, and is limited to 63.
- R5: While enabled, each channel's held level is the maximum magnitude over all samples since that channel's last read.
- R6: Reading a channel clears that channel's held level. The other channel keeps its level.
- R7: When a read and a sample valid fall in the same cycle, the read returns the level held before the sample. The held value then equals the new sample's magnitude.
- R8: The magnitude is the absolute value of the sample. The most negative sample, 24'h800000, saturates to 2^23−1 and reads code 0.
- R9: While the enable is low, samples are ignored, both held levels are cleared, and any channel read returns code 63.
- R10: A zero level, or any level whose ideal value is 63 or more (magnitude 5938 or below), reads exactly code 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Both channel samples are valid this cycle |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| track_en | input | 1 | Peak tracking enable |
| rd_addr | input | 4 | Register address for a read |
| rd_strobe | input | 1 | One-cycle read request |
| rd_data | output | 10 | Readback word, valid from the cycle after the strobe |

## Verification
The checker watches, on every cycle, these properties: the upper readback bits stay zero, `rd_data` holds without a strobe, unmapped addresses read zero, disabled tracking clears both levels and forces code 63, each held level only grows between reads, a read clears its channel, and a sample that collides with a read is kept. Only the bench scenarios can show the accuracy of the decibel conversion, because the ideal code comes from real-number logarithms. The same holds for the saturation of the most negative sample and the behaviour at the −63 dB threshold.

// File: rtl/spm_pkg.sv
// Package spm_pkg
// Shared constants and the fine-step table for the stereo peak meter.
// Assumes fractional attenuation is held in units of 1/16 dB (Q4).
package spm_pkg;

    // Number of mantissa bits used below the leading one
    localparam int MANT_BITS = 4;

    // Channel indices into per-channel arrays
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } spm_chan_e;

    // Attenuation gained by mantissa 1+m/16, in Q4 dB, rounded down so that
    // the converter never reports a level louder than the true one.
    function automatic logic [6:0] fine_q4(input logic [MANT_BITS-1:0] m);
        logic [6:0] v;
        case (m)
            4'd0:  v = 7'd0;
            4'd1:  v = 7'd8;
            4'd2:  v = 7'd16;
            4'd3:  v = 7'd23;
            4'd4:  v = 7'd31;
            4'd5:  v = 7'd37;
            4'd6:  v = 7'd44;
            4'd7:  v = 7'd50;
            4'd8:  v = 7'd56;
            4'd9:  v = 7'd62;
            4'd10: v = 7'd67;
            4'd11: v = 7'd72;
            4'd12: v = 7'd77;
            4'd13: v = 7'd82;
            4'd14: v = 7'd87;
            default: v = 7'd91;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/spm_abs_sat.sv
// Module spm_abs_sat
// Turns a two's-complement sample into an unsigned magnitude one bit narrower.
// Assumes SMP_W >= 2; the most negative input saturates to the largest magnitude.
module spm_abs_sat #(
    parameter int SMP_W = 24,
    localparam int MAG_W = SMP_W - 1
) (
    input  logic [SMP_W-1:0] smp,
    output logic [MAG_W-1:0] mag
);

    logic             is_neg;
    logic             is_min;
    logic [SMP_W-1:0] negated;

    // Absolute value with saturation of the single unrepresentable case
    always_comb begin
        is_neg  = smp[SMP_W-1];
        is_min  = is_neg && (smp[MAG_W-1:0] == '0);
        negated = (~smp) + SMP_W'(1);
        if (is_min)
            mag = '1;
        else if (is_neg)
            mag = negated[MAG_W-1:0];
        else
            mag = smp[MAG_W-1:0];
    end

endmodule

// File: rtl/spm_peak_hold.sv
// Module spm_peak_hold
// Holds the largest magnitude seen for one channel since the last clear.
// Assumes clr is a one-cycle pulse; a clear and a sample in the same cycle
// apply the clear first and then compare the sample against zero.
module spm_peak_hold #(
    parameter int MAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid,
    input  logic [MAG_W-1:0] mag,
    input  logic             clr,
    output logic [MAG_W-1:0] held
);

    logic [MAG_W-1:0] base;

    // Value the comparison starts from after any pending clear
    always_comb begin
        base = clr ? '0 : held;
    end

    // Track-and-hold register with synchronous reset and disable clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (!en)
            held <= '0;
        else if (valid && (mag > base))
            held <= mag;
        else
            held <= base;
    end

endmodule

// File: rtl/spm_log_code.sv
// Module spm_log_code
// Combinational linear-to-decibel converter: returns whole dB below 2^MAG_W.
// Assumes MAG_W > MANT_BITS + 1; zero and very low levels return CODE_MAX.
// Attenuation is over-estimated by at most about 0.6 dB, never under-estimated.
module spm_log_code
    import spm_pkg::*;
#(
    parameter int MAG_W  = 23,
    parameter int CODE_W = 6,
    localparam int LEAD_W   = $clog2(MAG_W),
    localparam int KW       = $clog2(MAG_W + 1),
    localparam int ATT_W    = 16,
    localparam int CODE_MAX = (1 << CODE_W) - 1
) (
    input  logic [MAG_W-1:0]  mag,
    output logic [CODE_W-1:0] code
);

    logic [LEAD_W-1:0]    lead;
    logic                 found;
    logic [KW-1:0]        octaves;
    logic [MAG_W-1:0]     norm;
    logic [MANT_BITS-1:0] mant;
    logic [ATT_W-1:0]     base_q4;
    logic [ATT_W-1:0]     att_q4;

    // Leading-one search, highest set bit wins
    always_comb begin
        lead  = '0;
        found = 1'b0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) begin
                lead  = LEAD_W'(i);
                found = 1'b1;
            end
        end
    end

    // Octave count below full scale and normalised mantissa bits
    always_comb begin
        octaves = KW'(MAG_W) - KW'(lead);
        norm    = mag << (LEAD_W'(MAG_W - 1) - lead);
        mant    = norm[MAG_W-2 -: MANT_BITS];
    end

    // Q4 attenuation: ceil of octaves*96.33 minus the floored mantissa gain
    always_comb begin
        base_q4 = ATT_W'(octaves) * ATT_W'(96)
                + ((ATT_W'(octaves) * ATT_W'(21) + ATT_W'(63)) >> 6);
        att_q4  = base_q4 - ATT_W'(fine_q4(mant));
    end

    // Whole-dB code clamped to the bottom of the range
    always_comb begin
        if (!found || (att_q4 >= ATT_W'(CODE_MAX * 16)))
            code = CODE_W'(CODE_MAX);
        else
            code = CODE_W'(att_q4 >> 4);
    end

endmodule

// File: rtl/stereo_peak_meter.sv
// Module stereo_peak_meter (top)
// Per-channel peak hold on a stereo sample stream with a clear-on-read
// decibel readback. One converter is shared by both channels behind the
// address decode. Reads complete one cycle after the strobe.
module stereo_peak_meter
    import spm_pkg::*;
#(
    parameter int          SMP_W      = 24,
    parameter int          ADDR_W     = 4,
    parameter int          RD_W       = 10,
    parameter int          CODE_W     = 6,
    parameter logic [3:0]  LEFT_ADDR  = 4'b0011,
    parameter logic [3:0]  RIGHT_ADDR = 4'b0100,
    localparam int         MAG_W      = SMP_W - 1,
    localparam int         NUM_CH     = 2,
    localparam int         CODE_MAX   = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_left,
    input  logic [SMP_W-1:0]  smp_right,
    input  logic              track_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_strobe,
    output logic [RD_W-1:0]   rd_data
);

    logic [SMP_W-1:0]  smp_ch  [NUM_CH];
    logic [MAG_W-1:0]  mag_ch  [NUM_CH];
    logic [MAG_W-1:0]  held_ch [NUM_CH];
    logic              hit_ch  [NUM_CH];
    logic [MAG_W-1:0]  mag_l, mag_r, held_l, held_r;
    logic [MAG_W-1:0]  sel_held;
    logic [CODE_W-1:0] sel_code;
    logic              any_hit;

    // Route ports into per-channel arrays and decode the read address
    always_comb begin
        smp_ch[CH_LEFT]  = smp_left;
        smp_ch[CH_RIGHT] = smp_right;
        hit_ch[CH_LEFT]  = rd_strobe && (rd_addr == ADDR_W'(LEFT_ADDR));
        hit_ch[CH_RIGHT] = rd_strobe && (rd_addr == ADDR_W'(RIGHT_ADDR));
    end

    // One magnitude stage and one hold register per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        spm_abs_sat #(.SMP_W(SMP_W)) u_abs (
            .smp (smp_ch[ch]),
            .mag (mag_ch[ch])
        );
        spm_peak_hold #(.MAG_W(MAG_W)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (track_en),
            .valid (smp_valid),
            .mag   (mag_ch[ch]),
            .clr   (hit_ch[ch]),
            .held  (held_ch[ch])
        );
    end

    // Named views of the channel state for the bound checker
    always_comb begin
        mag_l  = mag_ch[CH_LEFT];
        mag_r  = mag_ch[CH_RIGHT];
        held_l = held_ch[CH_LEFT];
        held_r = held_ch[CH_RIGHT];
    end

    // Pick the addressed channel ahead of the shared converter
    always_comb begin
        sel_held = hit_ch[CH_RIGHT] ? held_ch[CH_RIGHT] : held_ch[CH_LEFT];
        any_hit  = hit_ch[CH_LEFT] || hit_ch[CH_RIGHT];
    end

    spm_log_code #(.MAG_W(MAG_W), .CODE_W(CODE_W)) u_log (
        .mag  (sel_held),
        .code (sel_code)
    );

    // Readback register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_strobe) begin
            if (!any_hit)
                rd_data <= '0;
            else if (!track_en)
                rd_data <= RD_W'(CODE_MAX);
            else
                rd_data <= RD_W'(sel_code);
        end
    end

endmodule

// File: rtl/spm_checker.sv
// Module spm_checker
// Cycle-level properties of the peak meter, bound onto the top module.
module spm_checker #(
    parameter int         ADDR_W     = 4,
    parameter int         RD_W       = 10,
    parameter int         CODE_W     = 6,
    parameter int         MAG_W      = 23,
    parameter logic [3:0] LEFT_ADDR  = 4'b0011,
    parameter logic [3:0] RIGHT_ADDR = 4'b0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              track_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_strobe,
    input logic [RD_W-1:0]   rd_data,
    input logic [MAG_W-1:0]  mag_l,
    input logic [MAG_W-1:0]  held_l,
    input logic [MAG_W-1:0]  held_r
);

    logic rd_left, rd_right;
    assign rd_left  = rd_strobe && (rd_addr == ADDR_W'(LEFT_ADDR));
    assign rd_right = rd_strobe && (rd_addr == ADDR_W'(RIGHT_ADDR));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:CODE_W] == '0);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_left && !rd_right) |=> rd_data == '0);

    // R9
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !track_en |=> (held_l == '0) && (held_r == '0));

    // R9
    disabled_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_en && (rd_left || rd_right)) |=> rd_data == RD_W'((1 << CODE_W) - 1));

    // R5
    left_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && !rd_left) |=> held_l >= $past(held_l));

    // R5
    right_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && !rd_right) |=> held_r >= $past(held_r));

    // R6
    left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_left && !smp_valid) |=> held_l == '0);

    // R6
    right_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_right && !smp_valid) |=> held_r == '0);

    // R7
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_left && smp_valid && track_en) |=> held_l == $past(mag_l));

endmodule

bind stereo_peak_meter spm_checker #(
    .ADDR_W     (ADDR_W),
    .RD_W       (RD_W),
    .CODE_W     (CODE_W),
    .MAG_W      (MAG_W),
    .LEFT_ADDR  (LEFT_ADDR),
    .RIGHT_ADDR (RIGHT_ADDR)
) u_spm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .track_en  (track_en),
    .rd_addr   (rd_addr),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .mag_l     (mag_l),
    .held_l    (held_l),
    .held_r    (held_r)
);

// File: tb/tb_stereo_peak_meter.sv
module tb_stereo_peak_meter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        track_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_strobe = 1'b0;
    logic [9:0]  rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stereo_peak_meter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .track_en  (track_en),
        .rd_addr   (rd_addr),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data)
    );

    // Stimulus table: {left sample, right sample}
    localparam logic [47:0] VEC [12] = '{
        {24'h7FFFFF, 24'h000001},
        {24'h400000, 24'hC00000},
        {24'h800000, 24'h123456},
        {24'h001000, 24'hFFF000},
        {24'h001732, 24'h001733},
        {24'h000000, 24'h0B504F},
        {24'h05A9DF, 24'hFA5621},
        {24'h2D413C, 24'h000100},
        {24'hFFFFFF, 24'h3FFFFF},
        {24'h0CCCCD, 24'hF33333},
        {24'h010000, 24'hFEFFFF},
        {24'h0003E8, 24'h07A120}
    };

    function automatic int ideal_code(input logic [23:0] s);
        int  m;
        real att;
        if (s == 24'h800000)
            m = 8388607;
        else if (s[23])
            m = int'(24'((~s) + 24'd1));
        else
            m = int'(s);
        if (m == 0)
            return 63;
        att = 20.0 * $log10(8388608.0 / real'(m));
        if (att >= 63.0)
            return 63;
        return $rtoi($floor(att));
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_code(input string req, input logic [9:0] got, input logic [23:0] s);
        int id;
        id = ideal_code(s);
        check((got[9:6] == 4'd0) &&
              ((int'(got) == id) || (id < 63 && int'(got) == id + 1)),
              req, int'(got), id);
    endtask

    task automatic send(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [9:0] v);
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_addr   = a;
        @(negedge clk);
        rd_strobe = 1'b0;
        v = rd_data;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        logic [9:0] prev;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 10'd0, "R1 reset rd_data", int'(rd_data), 0);
        track_en = 1'b1;
        rd(4'b0011, v);
        check(v == 10'd63, "R1 left after reset", int'(v), 63);
        rd(4'b0100, v);
        check(v == 10'd63, "R1 right after reset", int'(v), 63);

        // R4 R8 R10: table walk, each read starts from a cleared level
        foreach (VEC[i]) begin
            send(VEC[i][47:24], VEC[i][23:0]);
            rd(4'b0011, v);
            check_code("R4 left table", v, VEC[i][47:24]);
            rd(4'b0100, v);
            check_code("R4 right table", v, VEC[i][23:0]);
        end

        // R8: most negative sample reads full scale
        send(24'h800000, 24'h000000);
        rd(4'b0011, v);
        check(v == 10'd0, "R8 saturated min", int'(v), 0);

        // R10: threshold magnitude 5938 and zero give exactly 63
        send(24'h001732, 24'hFFE8CE);
        rd(4'b0011, v);
        check(v == 10'd63, "R10 threshold left", int'(v), 63);
        rd(4'b0100, v);
        check(v == 10'd63, "R10 threshold negative right", int'(v), 63);

        // R5: maximum held across several samples
        send(24'h0003E8, 24'h000000);
        send(24'h07A120, 24'h000000);
        send(24'h0007D0, 24'h000000);
        rd(4'b0011, v);
        check_code("R5 held max", v, 24'h07A120);

        // R6: clear on read affects only the addressed channel
        send(24'h400000, 24'h200000);
        rd(4'b0011, v);
        check_code("R6 first left read", v, 24'h400000);
        rd(4'b0011, v);
        check(v == 10'd63, "R6 left cleared", int'(v), 63);
        rd(4'b0100, v);
        check_code("R6 right kept", v, 24'h200000);

        // R2: unmapped addresses read zero and do not clear
        send(24'h7FFFFF, 24'h000000);
        rd(4'b0101, v);
        check(v == 10'd0, "R2 unmapped 5", int'(v), 0);
        rd(4'b0000, v);
        check(v == 10'd0, "R2 unmapped 0", int'(v), 0);
        rd(4'b0011, v);
        check(v == 10'd0, "R2 left after unmapped", int'(v), 0);

        // R2: output holds without a strobe
        send(24'h100000, 24'h000000);
        rd(4'b0011, prev);
        repeat (4) @(negedge clk);
        check(rd_data == prev, "R2 hold", int'(rd_data), int'(prev));
        check_code("R3 R4 held code", rd_data, 24'h100000);

        // R7: read and sample in the same cycle
        send(24'h010000, 24'h000000);
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_addr   = 4'b0011;
        smp_valid = 1'b1;
        smp_left  = 24'h400000;
        @(negedge clk);
        rd_strobe = 1'b0;
        smp_valid = 1'b0;
        check_code("R7 read returns prior", rd_data, 24'h010000);
        rd(4'b0011, v);
        check_code("R7 sample kept", v, 24'h400000);

        // R9: disabled tracking ignores samples and reads 63
        track_en = 1'b0;
        send(24'h7FFFFF, 24'h7FFFFF);
        rd(4'b0011, v);
        check(v == 10'd63, "R9 disabled left", int'(v), 63);
        rd(4'b0100, v);
        check(v == 10'd63, "R9 disabled right", int'(v), 63);
        track_en = 1'b1;
        send(24'h7FFFFF, 24'h000000);
        @(negedge clk);
        track_en = 1'b0;
        @(negedge clk);
        track_en = 1'b1;
        rd(4'b0011, v);
        check(v == 10'd63, "R9 disable clears held", int'(v), 63);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule